// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Two-Channel Programmable Filter

This block is the programming port of a two-channel programmable low-pass filter. A controller sends 8-bit words over three wires: a serial clock, a serial data line and an active-high enable. The first bit sent is the most significant. The block samples the three wires with its own system clock. It moves one data bit into a shift register on each rising edge of the serial clock that comes while the enable is high. When the enable falls, it commits the word, but only if it saw exactly eight serial clock edges.

The two leading bits of a committed word select the target. Code 00 writes the first frequency word, which holds the oscillator test bit, the 3-bit octave-group code and the two low bits of the 7-bit step code. Code 01 writes the second frequency word, which holds the five high step bits. Code 11 writes the 6-bit gain code. Code 10 is reserved. The configuration registers are never cleared by reset. Software brings them to a known state by writing an all-zero data word to each address. The gain output is limited to 41, which is 20.5 dB in half-dB units.

The control path is a four-state machine:
- IDLE moves to SHIFT on a rising enable.
- SHIFT moves to COMMIT on a falling enable after exactly eight serial clock edges, and to DROP on a falling enable after any other count.
- COMMIT writes the word and returns to IDLE.
- DROP returns to IDLE without a write.

Top module: `serial_cfg_bank`

## Requirements
- R1: Bits are taken most significant first, one per rising serial clock edge while the enable is high. Bit 7 of the word is the first bit sent.
- R2: A committed word with bits [7:6] = 00 sets the oscillator test bit from bit 5, the octave code from bits [4:2] and step[1:0] from bits [1:0]. It leaves step[6:2] and the gain unchanged.
- R3: A committed word with bits [7:6] = 01 sets step[6:2] from bits [4:0]. Bit 5 is ignored, and the other outputs are unchanged.
- R4: A committed word with bits [7:6] = 11 loads the gain code from bits [5:0].
- R5: A word with bits [7:6] = 10 changes no output.
- R6: A word is discarded, with no output change, unless exactly 8 serial clock edges arrived while the enable was high. Seven edges and nine edges are both discarded.
- R7: Serial clock edges while the enable is low are ignored. They do not count toward the next word.
- R8: The gain output equals the stored code for codes 0 to 41. It is 41 for stored codes 42 to 63.
- R9: The reset input does not clear the configuration registers. A reset during a word abandons that word.
- R10: The outputs change on the 4th rising system clock edge after the enable falls, and at no other time.
- R11: An all-zero data word written to each of the three addresses drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Active-low reset of the control path only |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Active-high word enable; a word is committed when it falls |
| gain_code | output | 6 | Gain in half-dB units, limited to 41 |
| octave | output | 3 | Octave-group code |
| step | output | 7 | Step code within the octave group |
| osc_test | output | 1 | Oscillator test enable |

## Verification
Each serial wire passes two synchronizing flops and one edge flop. The state machine then needs one edge to reach COMMIT, and the registers need one more edge to load. A committed word therefore appears on the outputs at the 4th system clock edge after the enable is seen low. The bench's reference model records the cycle in which it lowered the enable and schedules the new values for that cycle plus four. It compares every output at each falling system clock edge, so a value that appears one cycle early or late is reported. Targeted checks are made only after the word has settled, and the latency check samples the cycle before the update and the cycle of the update.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    typedef enum logic [1:0] {
        ADDR_FREQ_A = 2'b00,
        ADDR_FREQ_B = 2'b01,
        ADDR_RSVD   = 2'b10,
        ADDR_GAIN   = 2'b11
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } shift_state_e;

endpackage

// File: rtl/cfg_sync_level.sv
module cfg_sync_level #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign level = pipe[STAGES-1];
endmodule

// File: rtl/cfg_ser_shifter.sv
module cfg_ser_shifter
    import cfg_bank_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_lvl,
    input  logic              sclk_lvl,
    input  logic              en_lvl,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    shift_state_e      state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              sclk_prev_q, en_prev_q;
    logic              sclk_rise, en_rise, en_fall;

    assign sclk_rise = sclk_lvl & ~sclk_prev_q;
    assign en_rise   = en_lvl & ~en_prev_q;
    assign en_fall   = ~en_lvl & en_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_rise) state_nx = ST_SHIFT;
            ST_SHIFT:  if (en_fall) state_nx = (cnt_q == CNT_FULL) ? ST_COMMIT : ST_DROP;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_DROP:   state_nx = ST_IDLE;
        endcase
    end

    // edge history, bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            en_prev_q   <= 1'b0;
            cnt_q       <= '0;
            shreg_q     <= '0;
        end else begin
            sclk_prev_q <= sclk_lvl;
            en_prev_q   <= en_lvl;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == ST_SHIFT && sclk_rise && !en_fall) begin
                shreg_q <= {shreg_q[WORD_W-2:0], data_lvl};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_stb  = (state_q == ST_COMMIT);
        wr_word = shreg_q;
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_bank_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int OCT_W    = 3,
    parameter int STEP_W   = 7,
    parameter int STEP_LO  = 2,
    parameter int GAIN_W   = 6,
    parameter int GAIN_MAX = 41
) (
    input  logic              clk,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_word,
    output logic [GAIN_W-1:0] gain_code,
    output logic [OCT_W-1:0]  octave,
    output logic [STEP_W-1:0] step,
    output logic              osc_test
);
    localparam int FA_W    = 1 + OCT_W + STEP_LO;
    localparam int STEP_HI = STEP_W - STEP_LO;
    localparam logic [GAIN_W-1:0] GAIN_LIM = GAIN_W'(GAIN_MAX);

    logic [FA_W-1:0]    fa_q;
    logic [STEP_HI-1:0] fb_q;
    logic [GAIN_W-1:0]  gain_q;
    reg_addr_e          addr;

    assign addr = reg_addr_e'(wr_word[WORD_W-1 -: 2]);

    // no reset: contents hold until software rewrites them
    always_ff @(posedge clk) begin
        if (wr_stb) begin
            unique case (addr)
                ADDR_FREQ_A: fa_q   <= wr_word[FA_W-1:0];
                ADDR_FREQ_B: fb_q   <= wr_word[STEP_HI-1:0];
                ADDR_GAIN:   gain_q <= wr_word[GAIN_W-1:0];
                ADDR_RSVD:   ;
            endcase
        end
    end

    always_comb begin
        osc_test  = fa_q[FA_W-1];
        octave    = fa_q[STEP_LO +: OCT_W];
        step      = {fb_q, fa_q[STEP_LO-1:0]};
        gain_code = (gain_q > GAIN_LIM) ? GAIN_LIM : gain_q;
    end
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int OCT_W       = 3,
    parameter int STEP_W      = 7,
    parameter int GAIN_W      = 6,
    parameter int GAIN_MAX    = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    output logic [GAIN_W-1:0] gain_code,
    output logic [OCT_W-1:0]  octave,
    output logic [STEP_W-1:0] step,
    output logic              osc_test
);
    logic [2:0]        lvl;
    logic              en_lvl;
    logic              wr_stb;
    logic [WORD_W-1:0] wr_word;

    cfg_sync_level #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_en, ser_clk, ser_data}),
        .level    (lvl)
    );

    assign en_lvl = lvl[2];

    cfg_ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_lvl (lvl[0]),
        .sclk_lvl (lvl[1]),
        .en_lvl   (en_lvl),
        .wr_stb   (wr_stb),
        .wr_word  (wr_word)
    );

    cfg_regfile #(
        .WORD_W(WORD_W), .OCT_W(OCT_W), .STEP_W(STEP_W), .STEP_LO(2),
        .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)
    ) u_regs (
        .clk       (clk),
        .wr_stb    (wr_stb),
        .wr_word   (wr_word),
        .gain_code (gain_code),
        .octave    (octave),
        .step      (step),
        .osc_test  (osc_test)
    );
endmodule

// File: rtl/serial_cfg_bank_chk.sv
module serial_cfg_bank_chk #(
    parameter int GAIN_MAX = 41
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_lvl,
    input logic       wr_stb,
    input logic [7:0] wr_word,
    input logic [5:0] gain_code,
    input logic [2:0] octave,
    input logic [6:0] step,
    input logic       osc_test
);
    localparam logic [5:0] LIM = 6'(GAIN_MAX);

    logic seen_a = 1'b0;
    logic seen_b = 1'b0;
    logic seen_g = 1'b0;
    logic seen_all;

    always_ff @(posedge clk) begin
        if (wr_stb && wr_word[7:6] == 2'b00) seen_a <= 1'b1;
        if (wr_stb && wr_word[7:6] == 2'b01) seen_b <= 1'b1;
        if (wr_stb && wr_word[7:6] == 2'b11) seen_g <= 1'b1;
    end
    assign seen_all = seen_a & seen_b & seen_g;

    a_r6_commit_follows_enable_fall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!$past(en_lvl) && $past(en_lvl, 2)));

    a_r2_freq_a_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && wr_word[7:6] == 2'b00) |->
            (osc_test == $past(wr_word[5]) && octave == $past(wr_word[4:2])
             && step[1:0] == $past(wr_word[1:0])));

    a_r3_freq_b_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && wr_word[7:6] == 2'b01) |-> step[6:2] == $past(wr_word[4:0]));

    a_r4_gain_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && wr_word[7:6] == 2'b11 && wr_word[5:0] <= LIM) |->
            gain_code == $past(wr_word[5:0]));

    a_r8_gain_limited: assert property (@(posedge clk) disable iff (!rst_n)
        seen_g |-> gain_code <= LIM);

    a_r5_reserved_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seen_all) && $past(wr_stb && wr_word[7:6] == 2'b10)) |->
            ($stable(gain_code) && $stable(octave) && $stable(step) && $stable(osc_test)));

    a_r10_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seen_all) && !$past(wr_stb)) |->
            ($stable(gain_code) && $stable(octave) && $stable(step) && $stable(osc_test)));
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(.GAIN_MAX(GAIN_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_lvl    (en_lvl),
    .wr_stb    (wr_stb),
    .wr_word   (wr_word),
    .gain_code (gain_code),
    .octave    (octave),
    .step      (step),
    .osc_test  (osc_test)
);

// File: tb/serial_cfg_bank_bench.sv
`timescale 1ns/1ps
module serial_cfg_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_en = 1'b0;
    logic [5:0] gain_code;
    logic [2:0] octave;
    logic [6:0] step;
    logic       osc_test;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct { int due; logic [7:0] w; } pend_t;
    pend_t pq[$];

    logic       exp_osc = 1'b0;
    logic [2:0] exp_oct = '0;
    logic [6:0] exp_step = '0;
    logic [5:0] exp_gain = '0;
    bit known_a = 0, known_b = 0, known_g = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_cfg_bank u_serial_cfg_bank (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .gain_code(gain_code), .octave(octave),
        .step(step), .osc_test(osc_test)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void apply_word(input logic [7:0] w);
        int g;
        case (w[7:6])
            2'b00: begin exp_osc = w[5]; exp_oct = w[4:2]; exp_step[1:0] = w[1:0]; known_a = 1; end
            2'b01: begin exp_step[6:2] = w[4:0]; known_b = 1; end
            2'b11: begin g = int'(w[5:0]); exp_gain = 6'((g > 41) ? 41 : g); known_g = 1; end
            default: ;
        endcase
    endfunction

    // R10: reference model compared on every clock
    always @(negedge clk) begin
        while (pq.size() > 0 && pq[0].due <= cyc) begin
            apply_word(pq[0].w);
            void'(pq.pop_front());
        end
        if (known_a) begin
            chk("R10 osc", int'(osc_test), int'(exp_osc));
            chk("R10 octave", int'(octave), int'(exp_oct));
            chk("R10 step_lo", int'(step[1:0]), int'(exp_step[1:0]));
        end
        if (known_b) chk("R10 step_hi", int'(step[6:2]), int'(exp_step[6:2]));
        if (known_g) chk("R10 gain", int'(gain_code), int'(exp_gain));
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [7:0] w, input int nbits, input int rst_at);
        int eff;
        ser_en = 1'b1;
        idle(3);
        for (int i = 0; i < nbits; i++) begin
            if (i == rst_at) begin
                rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(3);
            end
            ser_data = (i < 8) ? w[7-i] : 1'b0;
            idle(3);
            ser_clk = 1'b1;
            idle(3);
            ser_clk = 1'b0;
        end
        idle(3);
        ser_en = 1'b0;
        eff = (rst_at < 0) ? nbits : nbits - rst_at;
        if (eff == 8) pq.push_back('{cyc + 4, w});
    endtask

    task automatic put(input logic [7:0] w);
        send_word(w, 8, -1);
        idle(8);
    endtask

    task automatic stray_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = 1'b1; idle(3); ser_clk = 1'b1; idle(3); ser_clk = 1'b0;
        end
        idle(3);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);

        // R11: zero words to every address
        put(8'h00); put(8'h40); put(8'hC0);
        chk("R11 gain", int'(gain_code), 0);
        chk("R11 octave", int'(octave), 0);
        chk("R11 step", int'(step), 0);
        chk("R11 osc", int'(osc_test), 0);

        // R2: 00_1_101_10
        put(8'h36);
        chk("R2 osc", int'(osc_test), 1);
        chk("R2 octave", int'(octave), 5);
        chk("R2 step", int'(step), 2);
        chk("R2 gain unchanged", int'(gain_code), 0);

        // R3: 01_1_10110, bit 5 ignored
        put(8'h76);
        chk("R3 step", int'(step), 90);
        chk("R3 octave unchanged", int'(octave), 5);
        chk("R3 osc unchanged", int'(osc_test), 1);

        // R4 and R8
        put(8'hD7); chk("R4 gain 23", int'(gain_code), 23);
        put(8'hE9); chk("R8 gain 41 passes", int'(gain_code), 41);
        put(8'hEA); chk("R8 gain 42 limited", int'(gain_code), 41);
        put(8'hFF); chk("R8 gain 63 limited", int'(gain_code), 41);
        put(8'hE8); chk("R4 gain 40", int'(gain_code), 40);

        // R5: reserved address
        put(8'hBF);
        chk("R5 gain", int'(gain_code), 40);
        chk("R5 step", int'(step), 90);
        chk("R5 octave", int'(octave), 5);
        chk("R5 osc", int'(osc_test), 1);

        // R6: 7 and 9 edges discarded
        send_word(8'hC5, 7, -1); idle(8);
        chk("R6 seven edges", int'(gain_code), 40);
        send_word(8'hC5, 9, -1); idle(8);
        chk("R6 nine edges", int'(gain_code), 40);

        // R7: stray edges with enable low
        stray_clocks(3);
        put(8'hC5);
        chk("R7 word after stray edges", int'(gain_code), 5);

        // R9: reset keeps contents; reset mid-word abandons it
        rst_n = 1'b0; idle(4); rst_n = 1'b1; idle(4);
        chk("R9 gain kept", int'(gain_code), 5);
        chk("R9 step kept", int'(step), 90);
        chk("R9 octave kept", int'(octave), 5);
        send_word(8'hC9, 8, 3); idle(8);
        chk("R9 mid-word reset", int'(gain_code), 5);

        // R1: asymmetric pattern 01_0_11010
        put(8'h5A);
        chk("R1 msb first", int'(step[6:2]), 26);

        // R10: explicit latency
        send_word(8'hC3, 8, -1);
        idle(3);
        chk("R10 before update", int'(gain_code), 5);
        idle(1);
        chk("R10 at update", int'(gain_code), 3);
        idle(8);

        // R11 again from a non-zero state
        put(8'h00); put(8'h40); put(8'hC0);
        chk("R11 clear step", int'(step), 0);
        chk("R11 clear gain", int'(gain_code), 0);
        chk("R11 clear osc", int'(osc_test), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule